// File: doc/BRIEF.md
# Serial Image Frame Loader

This block sits between a byte-wide serial receiver and a compute engine that shares a single memory write port with it. After power-on it owns the write port. Each received byte (one-cycle valid strobe) is stored at the next memory address, beginning at address 0. Once a complete frame of `FRAME_BYTES` bytes (784 by default, one 28x28 8-bit image sent at 115200 baud) has been stored, the block issues a one-cycle start pulse to the engine and releases the write port.

The engine raises its done line when it finishes, and leaves it high. For that reason the loader re-arms only on a rising edge of done, never on its level. On re-arm it takes back the write port and resets its byte counter, so the next frame overwrites the previous image from address 0. Frames can therefore be streamed one after another without any reconfiguration. Bytes that arrive while the engine owns the port are discarded, and a sticky flag records that this happened. Reset is a power-on reset only.

Top module: `image_frame_dma`

## Requirements
- R1: While reset is held and in the first cycle after it, `portOwned` is 1, `startPulse` is 0, `overflowSeen` is 0, `memAddr` is 0, and `memWe` is 0 whenever `rxValid` is 0.
- R2: While `portOwned` is 1, a cycle with `rxValid` high drives `memWe`=1, `memWdata`=`rxData` and `memAddr`=the byte's index in the frame (0 for the first byte), combinationally in that same cycle.
- R3: `memWe` is 1 only in a cycle where `portOwned` and `rxValid` are both 1.
- R4: The cycle after the write of byte index `FRAME_BYTES-1`, `startPulse` is 1 for exactly one cycle and `portOwned` falls to 0.
- R5: A byte with `rxValid` high while `portOwned` is 0 is not written. `overflowSeen` becomes 1 in the following cycle and stays 1 until reset.
- R6: `portOwned` returns to 1 only in the cycle after a rising edge of `engineDone` (low in one cycle, high in the next). Such an edge is accepted during the start-pulse cycle as well as later.
- R7: When the block re-arms, `memAddr` restarts at 0, so the next frame overwrites the previous one byte for byte.
- R8: If `engineDone` is still high when a frame completes, the block stays released for as long as `engineDone` stays high, and also while it falls. It re-arms only after a new rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| rxData | input | DATA_W | Received byte |
| rxValid | input | 1 | One-cycle strobe marking `rxData` valid |
| engineDone | input | 1 | Compute engine finished (level, stays high) |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory write address |
| memWdata | output | DATA_W | Memory write data |
| startPulse | output | 1 | One-cycle start request to the engine |
| portOwned | output | 1 | High while loading (the loader owns the write port) |
| overflowSeen | output | 1 | Sticky: a byte was dropped while released |

## Verification
The embedded assertions check the following on every cycle:
- the start pulse lasts a single cycle and only ever follows a write of the final byte;
- ownership returns only after a done edge, with the address at zero;
- the counter advances by one per write;
- the drop flag follows any byte received while released, and never clears.

The bench scenarios are needed for the rest:
- the stored data and addresses across whole frames with and without gaps between bytes;
- overwriting by a second and a third frame;
- a done level that is held or falling and must not re-arm;
- a done edge that lands in the start-pulse cycle.

// File: rtl/frame_dma_pkg.sv
package frame_dma_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2
  } loadState_t;

  typedef struct packed {
    logic countStep;
    logic countClear;
    logic dropMark;
  } dpStrobe_t;

endpackage

// File: rtl/frame_dma_dpath.sv
module frame_dma_dpath
  import frame_dma_pkg::*;
#(
  parameter int FRAME_BYTES = 784,
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rxData,
  input  logic              engineDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              lastByte,
  output logic              doneRise,
  output logic              overflowSeen
);

  localparam int CNT_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic             doneQ;
  logic             dropFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (strobe.countClear) begin
      byteCnt <= '0;
    end else if (strobe.countStep) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      dropFlag <= 1'b0;
    end else begin
      doneQ <= engineDone;
      if (strobe.dropMark) dropFlag <= 1'b1;
    end
  end

  assign doneRise     = engineDone & ~doneQ;
  assign lastByte     = (byteCnt == LAST_IDX);
  assign memWdata     = rxData;
  assign overflowSeen = dropFlag;

  generate
    if (ADDR_W > CNT_W) begin : g_addrPad
      assign memAddr = {{(ADDR_W-CNT_W){1'b0}}, byteCnt};
    end else begin : g_addrTrim
      assign memAddr = byteCnt[ADDR_W-1:0];
    end
  endgenerate

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countStep && !strobe.countClear) |=> (byteCnt == $past(byteCnt) + 1'b1));

  // R5
  sticky_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowSeen |=> overflowSeen);

endmodule

// File: rtl/frame_dma_ctrl.sv
module frame_dma_ctrl
  import frame_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  logic      lastByte,
  input  logic      doneRise,
  output dpStrobe_t strobe,
  output logic      memWe,
  output logic      startPulse,
  output logic      portOwned
);

  loadState_t state, stateNext;
  logic       writeNow;
  logic       rearmNow;

  assign writeNow = (state == ST_LOAD) && rxValid;
  assign rearmNow = (state != ST_LOAD) && doneRise;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LOAD:  if (writeNow && lastByte) stateNext = ST_START;
      ST_START: stateNext = doneRise ? ST_LOAD : ST_RUN;
      ST_RUN:   if (doneRise) stateNext = ST_LOAD;
      default:  stateNext = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOAD;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.countStep  = writeNow && !lastByte;
    strobe.countClear = (writeNow && lastByte) || rearmNow;
    strobe.dropMark   = rxValid && (state != ST_LOAD);
  end

  assign memWe      = writeNow;
  assign startPulse = (state == ST_START);
  assign portOwned  = (state == ST_LOAD);

  // R4
  start_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R4
  start_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(memWe && lastByte));

  // R6
  rearm_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portOwned) |-> $past(doneRise));

endmodule

// File: rtl/image_frame_dma.sv
module image_frame_dma
  import frame_dma_pkg::*;
#(
  parameter int FRAME_BYTES = 784,
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              engineDone,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              startPulse,
  output logic              portOwned,
  output logic              overflowSeen
);

  dpStrobe_t strobe;
  logic      lastByte;
  logic      doneRise;

  frame_dma_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .lastByte   (lastByte),
    .doneRise   (doneRise),
    .strobe     (strobe),
    .memWe      (memWe),
    .startPulse (startPulse),
    .portOwned  (portOwned)
  );

  frame_dma_dpath #(
    .FRAME_BYTES (FRAME_BYTES),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
  ) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .rxData       (rxData),
    .engineDone   (engineDone),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .lastByte     (lastByte),
    .doneRise     (doneRise),
    .overflowSeen (overflowSeen)
  );

  // R5
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !portOwned) |=> overflowSeen);

  // R7
  rearm_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portOwned) |-> (memAddr == '0));

  // R3
  we_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (portOwned && rxValid));

endmodule

// File: tb/image_frame_dma_tb_top.sv
module image_frame_dma_tb_top;

  localparam int FB = 12;
  localparam int AW = 5;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] rxData = '0;
  logic          rxValid = 1'b0;
  logic          engineDone = 1'b0;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          startPulse;
  logic          portOwned;
  logic          overflowSeen;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [FB];

  always #10 clk = ~clk;

  image_frame_dma #(.FRAME_BYTES(FB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk (clk), .rstN (rstN), .rxData (rxData), .rxValid (rxValid),
    .engineDone (engineDone), .memWe (memWe), .memAddr (memAddr),
    .memWdata (memWdata), .startPulse (startPulse), .portOwned (portOwned),
    .overflowSeen (overflowSeen)
  );

  always @(posedge clk) if (memWe && int'(memAddr) < FB) model[memAddr] <= memWdata;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patA(input int i); return 8'(i * 7 + 3); endfunction
  function automatic logic [7:0] patB(input int i); return 8'(i * 13) ^ 8'h5A; endfunction
  function automatic logic [7:0] patC(input int i); return 8'(255 - i * 5); endfunction

  task automatic sendByte(input logic [7:0] b, input int idx, input bit expWrite);
    @(negedge clk);
    rxData = b; rxValid = 1'b1;
    #2;
    if (expWrite) begin
      chk("R2 memWe", int'(memWe), 1);
      chk("R2 memAddr", int'(memAddr), idx);
      chk("R2 memWdata", int'(memWdata), int'(b));
      if (idx != FB - 1) chk("R4 no early start", int'(startPulse), 0);
    end else begin
      chk("R5 dropped byte not written", int'(memWe), 0);
    end
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // sel: 0=A,1=B,2=C; gaps inserts idle cycles
  task automatic sendFrame(input int sel, input bit gaps, input bit raiseAtStart);
    for (int i = 0; i < FB; i++) begin
      logic [7:0] v;
      v = (sel == 0) ? patA(i) : (sel == 1) ? patB(i) : patC(i);
      sendByte(v, i, 1'b1);
      if (gaps && (i % 3 == 1) && i != FB - 1) begin
        #2 chk("R3 idle no write", int'(memWe), 0);
        @(negedge clk);
      end
    end
    #1;
    chk("R4 start pulse", int'(startPulse), 1);
    chk("R4 port released", int'(portOwned), 0);
    if (raiseAtStart) engineDone = 1'b1;
    @(negedge clk); #1;
    chk("R4 start one cycle", int'(startPulse), 0);
  endtask

  task automatic checkModel(input int sel, input string req);
    for (int i = 0; i < FB; i++) begin
      logic [7:0] v;
      v = (sel == 0) ? patA(i) : (sel == 1) ? patB(i) : patC(i);
      chk(req, int'(model[i]), int'(v));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < FB; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset portOwned", int'(portOwned), 1);
    chk("R1 reset startPulse", int'(startPulse), 0);
    chk("R1 reset overflowSeen", int'(overflowSeen), 0);
    chk("R1 reset memAddr", int'(memAddr), 0);
    chk("R1 reset memWe", int'(memWe), 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 after reset portOwned", int'(portOwned), 1);
    chk("R3 no write without valid", int'(memWe), 0);

    // frame 1, back-to-back bytes
    sendFrame(0, 1'b0, 1'b0);
    checkModel(0, "R2 frame1 stored");

    // bytes while released are dropped (R5)
    for (int k = 0; k < 3; k++) sendByte(8'hEE, 0, 1'b0);
    #1 chk("R5 overflow set", int'(overflowSeen), 1);
    checkModel(0, "R5 memory untouched");

    // rising edge of done re-arms (R6, R7)
    @(negedge clk); engineDone = 1'b1;
    @(negedge clk); #1;
    chk("R6 rearm after rise", int'(portOwned), 1);
    chk("R7 address restart", int'(memAddr), 0);

    // frame 2 with gaps; done held high throughout
    sendFrame(1, 1'b1, 1'b0);
    checkModel(1, "R7 frame2 overwrite");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      chk("R8 held done no rearm", int'(portOwned), 0);
    end
    chk("R5 overflow sticky", int'(overflowSeen), 1);
    engineDone = 1'b0;
    @(negedge clk); #1;
    chk("R6 falling done no rearm", int'(portOwned), 0);
    engineDone = 1'b1;
    @(negedge clk); #1;
    chk("R6 rearm after new rise", int'(portOwned), 1);
    chk("R7 address restart 2", int'(memAddr), 0);

    // frame 3: done drops while loading, rises during the start cycle
    engineDone = 1'b0;
    sendFrame(2, 1'b0, 1'b1);
    #1 chk("R6 rise in start cycle rearms", int'(portOwned), 1);
    checkModel(2, "R7 frame3 overwrite");
    chk("R5 overflow still set", int'(overflowSeen), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule